// File: doc/BRIEF.md
# Triple-Redundant Serial Shift Chain with Per-Copy Voting

This block is a serial shift chain built to ride through single-event upsets. Every logical stage holds its bit in three flip-flops. Each of those flip-flops has its own 2-of-3 majority voter in front of it, and that voter reads the three copies of the stage before it. Because voters are never shared, the vote is part of each flip-flop's input path rather than a separate stage. A wrong value in one copy, whether it comes from the flip-flop or from its voter, is outvoted when the chain shifts again.

The three copies of every stage are clocked from three separate clock inputs, which stand for three branches of a clock tree. A spurious edge on one branch therefore disturbs at most one copy in each stage. The voted serial output is the majority of the last stage. A per-stage flag shows when the three copies of a stage disagree.

Fault-injection inputs let a bench invert any single copy of any stage on a chosen clock edge. The logic between flip-flops is one three-input majority and one XOR, so the chain is meant to close timing comfortably at a 40 MHz internal clock.

Top module: `tmr_shift_chain`

## Requirements
- R1: While `srst` is high at a clock edge, all copies of all stages are cleared on that edge. Afterwards `ser_out` is 0 and `stage_mismatch` is all zeros. `srst` takes priority over `shift_en` and over fault injection.
- R2: While `shift_en` is high and no fault is injected, each edge moves the data one stage along the chain. The bit on `ser_in` at edge k appears on `ser_out` after edge k+STAGES-1, so the output is the input delayed by STAGES shifts. Stage 0 loads `ser_in` into all three of its copies, and `stage_mismatch` stays all zeros.
- R3: While `shift_en` is low, every copy keeps its value and `ser_out` does not change, whatever `ser_in` does.
- R4: One copy inverted by fault injection, in any stage and any copy, never changes the `ser_out` sequence compared with an unhardened shift register fed the same input.
- R5: An injection during a shift makes bit s of `stage_mismatch` (bit s is stage s, stage 0 is next to `ser_in`) go high after that edge, with all other bits low. The next shift clears every bit, because the following stage re-votes the data.
- R6: An injection while `shift_en` is low leaves bit s of `stage_mismatch` high for as long as the chain holds. The next shift clears it, and `ser_out` keeps matching the reference throughout.
- R7: An extra rising edge on `clk_b` alone never changes `ser_out`. After the next regular edge on all three clocks, `stage_mismatch` is all zeros.
- R8: Injection is requested by `flip_req` high at a clock edge. `flip_stage` is the stage index. `flip_copy` selects the copy: 0 is the copy clocked by `clk_a`, 1 the copy on `clk_b`, 2 the copy on `clk_c`, and 3 injects nothing. The selected copy stores the inverse of the value it would otherwise have taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock branch for copy 0 of every stage |
| clk_b | input | 1 | Clock branch for copy 1 of every stage |
| clk_c | input | 1 | Clock branch for copy 2 of every stage |
| srst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Shift enable; the chain holds while low |
| ser_in | input | 1 | Serial data input |
| flip_req | input | 1 | Fault injection strobe |
| flip_stage | input | $clog2(STAGES) | Stage whose copy is inverted |
| flip_copy | input | 2 | Copy index to invert (0..2; 3 = none) |
| ser_out | output | 1 | Majority of the last stage's copies |
| stage_mismatch | output | STAGES | Bit s high when the copies of stage s disagree |

## Verification
The chain is driven with these input streams, each compared with an unhardened reference shift register:
- A constant-one stream shows that every stage passes data at all.
- An alternating stream and a sparse walking-one stream expose an off-by-one in the delay or a stuck stage.
- A pseudo-random stream covers mixed runs.

A sweep then inverts every copy of every stage, once during a shift and once during a hold. This tells a masked upset apart from a corrected one: the mismatch flag must point at exactly the faulted stage and then clear. Hold periods with a toggling input show that data does not leak in while the chain is held. Extra edges on a single clock branch show that a glitch on one branch is absorbed like any single-copy upset.

// File: rtl/tmr_chain_pkg.sv
package tmr_chain_pkg;

  localparam int COPIES = 3;

  typedef logic [COPIES-1:0] triplet_t;

  // 2-of-3 majority of a triplet
  function automatic logic maj3(input triplet_t t);
    return (t[0] & t[1]) | (t[0] & t[2]) | (t[1] & t[2]);
  endfunction

  // true when all copies hold the same value
  function automatic logic agree3(input triplet_t t);
    return (t == '0) || (t == '1);
  endfunction

endpackage

// File: rtl/tmr_fault_decode.sv
module tmr_fault_decode
  import tmr_chain_pkg::*;
#(
  parameter int STAGES = 16,
  localparam int STG_W = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic                     flip_req,
  input  logic [STG_W-1:0]         flip_stage,
  input  logic [1:0]               flip_copy,
  output triplet_t [STAGES-1:0]    inj_m
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    for (genvar k = 0; k < COPIES; k++) begin : g_copy
      assign inj_m[s][k] = flip_req
                         && (flip_stage == STG_W'(s))
                         && (flip_copy == 2'(k));
    end
  end

endmodule

// File: rtl/tmr_cell.sv
module tmr_cell
  import tmr_chain_pkg::*;
(
  input  logic     clk,
  input  logic     srst,
  input  logic     shift_en,
  input  triplet_t upstream,
  input  logic     inj,
  output logic     q
);

  logic vote_w;     // this copy's private voter
  logic d_w;

  assign vote_w = maj3(upstream);
  assign d_w    = (shift_en ? vote_w : q) ^ inj;

  always_ff @(posedge clk) begin
    if (srst) q <= 1'b0;
    else      q <= d_w;
  end

  // R1
  clear_on_reset_chk: assert property (@(posedge clk) srst |=> (q == 1'b0));

endmodule

// File: rtl/tmr_stage.sv
module tmr_stage
  import tmr_chain_pkg::*;
(
  input  triplet_t clk_br,
  input  logic     srst,
  input  logic     shift_en,
  input  triplet_t prev_q,
  input  triplet_t inj,
  output triplet_t q_o,
  output logic     mismatch_o
);

  logic inj_any;

  assign inj_any = |inj;

  for (genvar k = 0; k < COPIES; k++) begin : g_copy
    tmr_cell u_cell (
      .clk      (clk_br[k]),
      .srst     (srst),
      .shift_en (shift_en),
      .upstream (prev_q),
      .inj      (inj[k]),
      .q        (q_o[k])
    );
  end

  assign mismatch_o = !agree3(q_o);

  // R3
  hold_stable_chk: assert property (@(posedge clk_br[0]) disable iff (srst)
    (!shift_en && !inj_any) |=> $stable(q_o));

  // R6
  hold_flip_seen_chk: assert property (@(posedge clk_br[0]) disable iff (srst)
    (!shift_en && inj_any && !mismatch_o) |=> mismatch_o);

endmodule

// File: rtl/tmr_shift_chain.sv
module tmr_shift_chain
  import tmr_chain_pkg::*;
#(
  parameter int STAGES = 16,
  localparam int STG_W = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              clk_c,
  input  logic              srst,
  input  logic              shift_en,
  input  logic              ser_in,
  input  logic              flip_req,
  input  logic [STG_W-1:0]  flip_stage,
  input  logic [1:0]        flip_copy,
  output logic              ser_out,
  output logic [STAGES-1:0] stage_mismatch
);

  triplet_t              clk_br;
  triplet_t [STAGES-1:0] q_m;
  triplet_t [STAGES-1:0] inj_m;

  assign clk_br = {clk_c, clk_b, clk_a};

  tmr_fault_decode #(.STAGES(STAGES)) u_decode (
    .flip_req   (flip_req),
    .flip_stage (flip_stage),
    .flip_copy  (flip_copy),
    .inj_m      (inj_m)
  );

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    triplet_t prev_w;
    if (s == 0) begin : g_head
      assign prev_w = {COPIES{ser_in}};
    end else begin : g_body
      assign prev_w = q_m[s-1];
    end

    tmr_stage u_stage (
      .clk_br     (clk_br),
      .srst       (srst),
      .shift_en   (shift_en),
      .prev_q     (prev_w),
      .inj        (inj_m[s]),
      .q_o        (q_m[s]),
      .mismatch_o (stage_mismatch[s])
    );
  end

  assign ser_out = maj3(q_m[STAGES-1]);

  // R1
  reset_clears_chk: assert property (@(posedge clk_a)
    srst |=> ((stage_mismatch == '0) && !ser_out));

  // R3
  out_held_chk: assert property (@(posedge clk_a) disable iff (srst)
    !shift_en |=> $stable(ser_out));

endmodule

// File: tb/test_tmr_shift_chain.sv
`timescale 1ns/1ps
module test_tmr_shift_chain;
  localparam int N = 16;
  localparam int SW = $clog2(N);

  logic clk = 1'b0, glit = 1'b0;
  logic srst = 1'b1, shift_en = 1'b0, ser_in = 1'b0, flip_req = 1'b0;
  logic [SW-1:0] flip_stage = '0;
  logic [1:0] flip_copy = 2'd3;
  logic ser_out;
  logic [N-1:0] stage_mismatch;
  logic clk_b;

  int errors = 0, checks = 0;
  logic [N-1:0] ref_q = '0;
  logic [6:0] lfsr_st = 7'h5A;

  always #10 clk = ~clk;
  assign clk_b = clk | glit;

  tmr_shift_chain #(.STAGES(N)) i_tmr_shift_chain (
    .clk_a(clk), .clk_b(clk_b), .clk_c(clk),
    .srst(srst), .shift_en(shift_en), .ser_in(ser_in),
    .flip_req(flip_req), .flip_stage(flip_stage), .flip_copy(flip_copy),
    .ser_out(ser_out), .stage_mismatch(stage_mismatch)
  );

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_out(input string tag);
    chk(ser_out === ref_q[N-1], tag, N'(ser_out), N'(ref_q[N-1]));
  endtask

  task automatic chk_mm(input string tag, input logic [N-1:0] exp);
    chk(stage_mismatch === exp, tag, stage_mismatch, exp);
  endtask

  task automatic next_rand(output logic b);
    b = lfsr_st[6];
    lfsr_st = {lfsr_st[5:0], lfsr_st[6] ^ lfsr_st[5]};
  endtask

  // one clock cycle; results sampled 5 ns after the rising edge
  task automatic cyc(input logic d, input logic en, input logic rs,
                     input logic fi, input int fs, input int fc, input bit glitch);
    @(negedge clk);
    ser_in = d; shift_en = en; srst = rs; flip_req = fi;
    flip_stage = SW'(fs); flip_copy = 2'(fc);
    if (glitch) begin
      #3 glit = 1'b1;
      #2 glit = 1'b0;
      #2 chk_out("R7 output after lone clk_b edge");
    end
    @(posedge clk);
    if (rs) ref_q = '0;
    else if (en) ref_q = {ref_q[N-2:0], d};
    #5;
    flip_req = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic b;
    logic held;
    // R1: reset state
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b1, 1'b0, 0, 3, 1'b0);
    chk_out("R1 out after reset");
    chk_mm("R1 mismatch after reset", '0);
    for (int i = 0; i < N; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 0, 3, 1'b0);
    chk_out("R2 ones filled");
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 3, 1, 1'b0);
    chk(ser_out === 1'b0, "R1 out cleared over data", N'(ser_out), '0);
    chk_mm("R1 mismatch cleared, reset beats injection", '0);
    for (int i = 0; i < N; i++) begin
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 0, 3, 1'b0);
      chk_out("R1 zeros after reset");
    end

    // R2: several input patterns
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 40; i++) begin
        case (p)
          0: b = 1'b1;
          1: b = 1'(i % 2);
          2: b = (i % 7 == 0);
          default: next_rand(b);
        endcase
        cyc(b, 1'b1, 1'b0, 1'b0, 0, 3, 1'b0);
        chk_out("R2 delayed output");
        chk_mm("R2 no mismatch", '0);
      end
    end

    // R3: hold ignores ser_in
    held = ser_out;
    for (int i = 0; i < 6; i++) begin
      cyc(1'(i % 2), 1'b0, 1'b0, 1'b0, 0, 3, 1'b0);
      chk(ser_out === held, "R3 held output", N'(ser_out), N'(held));
      chk_mm("R3 no mismatch in hold", '0);
    end
    for (int i = 0; i < N + 4; i++) begin
      next_rand(b);
      cyc(b, 1'b1, 1'b0, 1'b0, 0, 3, 1'b0);
      chk_out("R3 resume after hold");
    end

    // R4, R5: every stage and copy flipped during a shift
    for (int s = 0; s < N; s++) begin
      for (int c = 0; c < 3; c++) begin
        next_rand(b);
        cyc(b, 1'b1, 1'b0, 1'b1, s, c, 1'b0);
        chk_mm("R5 flag on faulted stage", N'(1) << s);
        chk_out("R4 output masked");
        next_rand(b);
        cyc(b, 1'b1, 1'b0, 1'b0, 0, 3, 1'b0);
        chk_mm("R5 flag cleared by next shift", '0);
        chk_out("R4 output after correction");
      end
    end
    // R8: copy index 3 injects nothing
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 5, 3, 1'b0);
    chk_mm("R8 copy 3 is no-op", '0);
    chk_out("R8 output unchanged");

    // R6: flips during hold
    for (int s = 0; s < N; s++) begin
      for (int c = 0; c < 3; c++) begin
        cyc(1'b0, 1'b0, 1'b0, 1'b1, s, c, 1'b0);
        chk_mm("R6 flag set in hold", N'(1) << s);
        chk_out("R6 output masked in hold");
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, 3, 1'b0);
        chk_mm("R6 flag persists in hold", N'(1) << s);
        next_rand(b);
        cyc(b, 1'b1, 1'b0, 1'b0, 0, 3, 1'b0);
        chk_mm("R6 flag cleared by shift", '0);
        chk_out("R6 output after shift");
      end
    end

    // R7: lone edge on clk_b while shifting
    for (int i = 0; i < 10; i++) begin
      next_rand(b);
      cyc(b, 1'b1, 1'b0, 1'b0, 0, 3, 1'b1);
      chk_out("R7 output after regular edge");
      chk_mm("R7 copies re-agree", '0);
      next_rand(b);
      cyc(b, 1'b1, 1'b0, 1'b0, 0, 3, 1'b0);
      chk_out("R7 output follows reference");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule